// File: doc/BRIEF.md
# Graph-Coloring Flip Energy Evaluator

This unit serves a stochastic graph-coloring solver in which every vertex carries its color as a compact binary code of ⌈log2 q⌉ bits rather than a one-hot word. Given a target vertex and one bit position of its code, the unit builds two trial codes for that vertex: one with the selected bit cleared and one with it set. It then walks over every other vertex, one per cycle. For each vertex it fetches the edge weight from an external weight store and evaluates a conflict operator for each trial code. It adds the weight to the energy of each trial whose operator returns 1.

The conflict operator is 1 when the two codes are identical, or when either code is not a legal color (greater than or equal to the active color count q). Otherwise it is 0. The result is the energy of the "bit = 1" trial minus the energy of the "bit = 0" trial, clamped to a signed 8-bit value. The sampling stage uses this result to decide the new value of the bit. The sampling stage and the loading of weights lie outside this unit.

Requests enter through a valid/ready handshake and results leave through another. A request is taken only while the unit is idle. A result stays on the output, unchanged, until the consumer raises ready. The defaults cover 256 fully connected vertices with up to 16 colors, which is 4-bit codes and 1024 binary neurons.

Top module: `cge_energy_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and both `res_valid` and `wt_rd_en` are 0.
- R2: A vertex whose code equals a trial code (both legal) adds that pair's weight to that trial's energy.
- R3: A pair in which the trial code or the other vertex's code is greater than or equal to `req_colors` counts as a conflict and adds the pair's weight to that trial's energy.
- R4: A pair of distinct legal codes adds nothing to either trial.
- R5: `res_energy` equals the sum over all vertices j other than the target of w(target,j)·(F(code1,s_j) − F(code0,s_j)). The self pair is excluded, and weights are signed two's complement.
- R6: A sum above 127 is presented as 127, and a sum below −128 is presented as −128. Values inside that range pass unchanged.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the result has been taken, and requests offered during that time are ignored.
- R8: `res_valid` rises exactly NODES+1 clock cycles after the edge that accepted the request.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_energy` hold their values. The result is dropped on the edge where both are 1.
- R10: For each request the unit issues exactly NODES−1 weight reads. Each read uses row = target vertex, and the columns ascend and skip the target. The weight store returns `wt_rd_data` one cycle after `wt_rd_en`.
- R11: `req_bit` selects a bit of the target's 4-bit code, with bit 0 the LSB. Vertex i's code occupies `state_codes[4i+3:4i]`, and the state must stay stable until the result is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_colors | input | 5 | Active color count q (legal codes 0..q−1) |
| req_node | input | 8 | Target vertex index |
| req_bit | input | 2 | Bit of the target code to evaluate |
| state_codes | input | 1024 | Color codes of all vertices, 4 bits each |
| wt_rd_en | output | 1 | Weight read strobe |
| wt_rd_row | output | 8 | Weight row (target vertex) |
| wt_rd_col | output | 8 | Weight column (other vertex) |
| wt_rd_data | input | 8 | Signed weight, returned one cycle after the strobe |
| res_valid | output | 1 | Energy difference available |
| res_ready | input | 1 | Consumer takes the result |
| res_energy | output | 8 | Saturated signed energy difference |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Colors that are illegal only because q is smaller than the code space.** A design that tested only code equality would report zero or the wrong sign for these.
- **Target vertices 0 and 255.** A scan that mishandles its first or last column would lose or duplicate one weight, or read the self weight.
- **Sums that land exactly on 127 and −128, and sums far beyond them with weights of both signs.** A clamp that is off by one or wraps would produce the opposite sign.
- **Long back-pressure, and a request held high while the unit is busy.** A unit that dropped the result early or restarted the scan would change the energy or shift the result's arrival cycle away from NODES+1.

// File: rtl/cge_pkg.sv
package cge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } cge_state_e;

endpackage

// File: rtl/cge_conflict.sv
module cge_conflict #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [CODE_W:0]   num_colors,
  output logic              hit
);
  logic same, a_bad, b_bad;

  always_comb begin
    same  = (code_a == code_b);
    a_bad = ({1'b0, code_a} >= num_colors);
    b_bad = ({1'b0, code_b} >= num_colors);
    hit   = same | a_bad | b_bad;
  end
endmodule

// File: rtl/cge_pair_delta.sv
module cge_pair_delta #(
  parameter int CODE_W   = 4,
  parameter int WEIGHT_W = 8,
  parameter int ACC_W    = 17
) (
  input  logic [CODE_W-1:0]        trial0,
  input  logic [CODE_W-1:0]        trial1,
  input  logic [CODE_W-1:0]        other,
  input  logic [CODE_W:0]          num_colors,
  input  logic [WEIGHT_W-1:0]      weight,
  output logic signed [ACC_W-1:0]  delta
);
  logic [1:0]              hit;
  logic [1:0][CODE_W-1:0]  trials;
  logic signed [ACC_W-1:0] w_ext;

  assign trials[0] = trial0;
  assign trials[1] = trial1;

  for (genvar g = 0; g < 2; g++) begin : g_trial
    cge_conflict #(.CODE_W(CODE_W)) u_conf (
      .code_a     (trials[g]),
      .code_b     (other),
      .num_colors (num_colors),
      .hit        (hit[g])
    );
  end

  always_comb begin
    w_ext = {{(ACC_W-WEIGHT_W){weight[WEIGHT_W-1]}}, weight};
    case (hit)
      2'b10:   delta = w_ext;
      2'b01:   delta = -w_ext;
      default: delta = '0;
    endcase
  end
endmodule

// File: rtl/cge_scan_ctrl.sv
module cge_scan_ctrl
  import cge_pkg::*;
#(
  parameter int NODES  = 256,
  parameter int NODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NODE_W-1:0] target,
  input  logic              res_ready,
  output logic              idle,
  output logic              done,
  output logic              rd_en,
  output logic [NODE_W-1:0] rd_col,
  output logic              pipe_vld,
  output logic [NODE_W-1:0] pipe_idx
);
  localparam logic [NODE_W-1:0] LAST = NODE_W'(NODES - 1);

  cge_state_e        st;
  logic [NODE_W-1:0] idx;

  always_comb begin
    idle   = (st == ST_IDLE);
    done   = (st == ST_DONE);
    rd_en  = (st == ST_SCAN) && (idx != target);
    rd_col = idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      pipe_vld <= 1'b0;
      pipe_idx <= '0;
    end else begin
      pipe_vld <= rd_en;
      pipe_idx <= idx;
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_SCAN;
          idx <= '0;
        end
        ST_SCAN: if (idx == LAST) st <= ST_DRAIN;
                 else idx <= idx + 1'b1;
        ST_DRAIN: st <= ST_DONE;
        ST_DONE: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cge_accum.sv
module cge_accum #(
  parameter int ACC_W = 17,
  parameter int RES_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    add_en,
  input  logic signed [ACC_W-1:0] delta,
  output logic [RES_W-1:0]        result
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (RES_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  logic signed [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (add_en) acc <= acc + delta;
  end

  always_comb begin
    if (acc > SAT_HI)      result = SAT_HI[RES_W-1:0];
    else if (acc < SAT_LO) result = SAT_LO[RES_W-1:0];
    else                   result = acc[RES_W-1:0];
  end
endmodule

// File: rtl/cge_energy_unit.sv
module cge_energy_unit #(
  parameter int NODES    = 256,
  parameter int CODE_W   = 4,
  parameter int WEIGHT_W = 8,
  parameter int RES_W    = 8,
  localparam int NODE_W  = $clog2(NODES),
  localparam int BIT_W   = $clog2(CODE_W),
  localparam int ACC_W   = WEIGHT_W + NODE_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [CODE_W:0]           req_colors,
  input  logic [NODE_W-1:0]         req_node,
  input  logic [BIT_W-1:0]          req_bit,
  input  logic [NODES*CODE_W-1:0]   state_codes,
  output logic                      wt_rd_en,
  output logic [NODE_W-1:0]         wt_rd_row,
  output logic [NODE_W-1:0]         wt_rd_col,
  input  logic [WEIGHT_W-1:0]       wt_rd_data,
  output logic                      res_valid,
  input  logic                      res_ready,
  output logic [RES_W-1:0]          res_energy
);
  logic                    start, idle, done, pipe_vld;
  logic [NODE_W-1:0]       pipe_idx;
  logic [NODE_W-1:0]       tgt_r;
  logic [CODE_W:0]         q_r;
  logic [CODE_W-1:0]       cur_code, trial0_r, trial1_r, other_code;
  logic signed [ACC_W-1:0] delta;

  assign start     = req_valid && idle;
  assign req_ready = idle;
  assign res_valid = done;
  assign wt_rd_row = tgt_r;

  always_comb begin
    cur_code   = state_codes[int'(req_node) * CODE_W +: CODE_W];
    other_code = state_codes[int'(pipe_idx) * CODE_W +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_r    <= '0;
      q_r      <= '0;
      trial0_r <= '0;
      trial1_r <= '0;
    end else if (start) begin
      tgt_r    <= req_node;
      q_r      <= req_colors;
      trial0_r <= cur_code & ~(CODE_W'(1) << req_bit);
      trial1_r <= cur_code |  (CODE_W'(1) << req_bit);
    end
  end

  cge_scan_ctrl #(.NODES(NODES), .NODE_W(NODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .target    (tgt_r),
    .res_ready (res_ready),
    .idle      (idle),
    .done      (done),
    .rd_en     (wt_rd_en),
    .rd_col    (wt_rd_col),
    .pipe_vld  (pipe_vld),
    .pipe_idx  (pipe_idx)
  );

  cge_pair_delta #(.CODE_W(CODE_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_pair (
    .trial0     (trial0_r),
    .trial1     (trial1_r),
    .other      (other_code),
    .num_colors (q_r),
    .weight     (wt_rd_data),
    .delta      (delta)
  );

  cge_accum #(.ACC_W(ACC_W), .RES_W(RES_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .add_en (pipe_vld),
    .delta  (delta),
    .result (res_energy)
  );
endmodule

// File: rtl/cge_checker.sv
module cge_checker #(
  parameter int NODES  = 256,
  parameter int NODE_W = 8,
  parameter int RES_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wt_rd_en,
  input logic [NODE_W-1:0] wt_rd_row,
  input logic [NODE_W-1:0] wt_rd_col,
  input logic              res_valid,
  input logic              res_ready,
  input logic [RES_W-1:0]  res_energy
);
  localparam int CW = $clog2(NODES + 3) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] LAT     = CW'(NODES + 1);

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                       lat_cnt <= '0;
    else if (req_valid && req_ready)  lat_cnt <= '0;
    else if (lat_cnt != CNT_MAX)      lat_cnt <= lat_cnt + 1'b1;
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wt_rd_en); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_energy))); // R9
  AST_NO_SELF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wt_rd_en |-> (wt_rd_col != wt_rd_row)); // R10
  AST_COL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_rd_en && $past(wt_rd_en)) |-> ((wt_rd_col > $past(wt_rd_col)) && $stable(wt_rd_row))); // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_cnt == LAT)); // R8
endmodule

bind cge_energy_unit cge_checker #(.NODES(NODES), .NODE_W(NODE_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .wt_rd_en   (wt_rd_en),
  .wt_rd_row  (wt_rd_row),
  .wt_rd_col  (wt_rd_col),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_energy (res_energy)
);

// File: tb/tb_cge_energy_unit.sv
module tb_cge_energy_unit;
  localparam int NODES  = 256;
  localparam int CODE_W = 4;
  localparam int NODE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CODE_W:0] req_colors = '0;
  logic [NODE_W-1:0] req_node = '0;
  logic [1:0] req_bit = '0;
  logic [NODES*CODE_W-1:0] st = '0;
  logic wt_rd_en;
  logic [NODE_W-1:0] wt_rd_row, wt_rd_col;
  logic [7:0] wt_rd_data = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [7:0] res_energy;

  always #4 clk = ~clk;

  cge_energy_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_colors(req_colors), .req_node(req_node), .req_bit(req_bit),
    .state_codes(st), .wt_rd_en(wt_rd_en), .wt_rd_row(wt_rd_row),
    .wt_rd_col(wt_rd_col), .wt_rd_data(wt_rd_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_energy(res_energy)
  );

  int checks = 0;
  int fails = 0;
  int wmode = 0;
  int wconst = 0;
  int active = 0;
  int wseed = 0;
  string cur_tag = "R1";

  function automatic int code_of(int j);
    return int'(st[j*CODE_W +: CODE_W]);
  endfunction

  function automatic int wfun(int i, int j);
    if (j >= active) return 0;
    if (wmode == 0) return wconst;
    return ((i * 37 + j * 101 + wseed) % 255) - 127;
  endfunction

  function automatic int conf(int a, int s, int q);
    return ((a == s) || (a >= q) || (s >= q)) ? 1 : 0;
  endfunction

  function automatic int ref_energy(int q, int t, int b);
    int c, c0, c1, acc;
    acc = 0;
    c  = code_of(t);
    c0 = c & ~(1 << b);
    c1 = c | (1 << b);
    for (int j = 0; j < NODES; j++)
      if (j != t) acc += wfun(t, j) * (conf(c1, code_of(j), q) - conf(c0, code_of(j), q));
    if (acc > 127) acc = 127;
    if (acc < -128) acc = -128;
    return acc;
  endfunction

  // weight store: one cycle read latency
  always @(posedge clk)
    wt_rd_data <= wt_rd_en ? 8'(wfun(int'(wt_rd_row), int'(wt_rd_col))) : 8'hA5;

  // behavioural reference model
  bit m_busy = 0, m_valid = 0;
  int m_cnt = 0, m_energy = 0, m_tgt = 0, m_reads = 0, m_prevcol = -1;
  bit m_first = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_cnt = 0;
    end else if (!m_busy && !m_valid) begin
      if (req_valid) begin
        m_busy = 1; m_cnt = NODES + 1; m_tgt = int'(req_node);
        m_energy = ref_energy(int'(req_colors), int'(req_node), int'(req_bit));
        m_reads = 0; m_prevcol = -1;
      end
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin m_busy = 0; m_valid = 1; m_first = 1; end
    end else if (m_valid && res_ready) begin
      m_valid = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == (!m_busy && !m_valid), "R7 ready", int'(req_ready), int'(!m_busy && !m_valid));
      check(res_valid == m_valid, "R8 valid", int'(res_valid), int'(m_valid));
      if (m_valid && res_valid)
        check($signed(res_energy) == m_energy, cur_tag, int'($signed(res_energy)), m_energy);
      if (wt_rd_en) begin
        check(int'(wt_rd_row) == m_tgt && int'(wt_rd_col) != m_tgt && int'(wt_rd_col) > m_prevcol,
              "R10 read addr", int'(wt_rd_col), m_prevcol + 1);
        m_prevcol = int'(wt_rd_col);
        m_reads++;
      end
      if (m_valid && m_first) begin
        check(m_reads == NODES - 1, "R10 read count", m_reads, NODES - 1);
        m_first = 0;
      end
    end
  end

  task automatic run_op(input int q, input int t, input int b, input string tag,
                        input int hold, input bit spurious);
    @(negedge clk);
    cur_tag = tag;
    req_colors = 5'(q); req_node = 8'(t); req_bit = 2'(b);
    req_valid = 1'b1;
    if (hold > 0) res_ready = 1'b0;
    @(negedge clk);
    if (spurious) begin
      req_node = 8'(t ^ 8'h55);
      repeat (20) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    res_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill_codes(input int kind, input int p);
    for (int j = 0; j < NODES; j++) begin
      int c;
      case (kind)
        0: c = p;
        1: c = j % 16;
        default: c = (j * 7 + p) % 16;
      endcase
      st[j*CODE_W +: CODE_W] = 4'(c);
    end
  endtask

  task automatic set_code(input int j, input int c);
    st[j*CODE_W +: CODE_W] = 4'(c);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1 && res_valid == 1'b0 && wt_rd_en == 1'b0, "R1",
          {29'd0, req_ready, res_valid, wt_rd_en}, 4);

    // R2 equal legal codes
    wmode = 0; wconst = 10; active = 4;
    fill_codes(0, 0);
    set_code(0, 2); set_code(1, 3); set_code(2, 2); set_code(3, 1);
    run_op(4, 0, 1, "R2", 0, 0);
    run_op(4, 0, 0, "R2", 0, 0);

    // R3 illegal codes relative to q
    set_code(0, 1); set_code(1, 2); set_code(2, 0); set_code(3, 0);
    run_op(3, 0, 1, "R3", 0, 0);
    set_code(1, 3);
    run_op(3, 0, 0, "R3", 0, 0);
    run_op(0, 2, 0, "R3", 0, 0);

    // R4 distinct legal codes add nothing
    active = 8;
    for (int j = 1; j < 8; j++) set_code(j, j);
    set_code(0, 8);
    run_op(16, 0, 0, "R4", 0, 0);

    // R11 bit selection
    set_code(3, 0); set_code(4, 4); set_code(1, 1);
    run_op(16, 3, 2, "R11", 0, 0);
    run_op(16, 3, 0, "R11", 0, 0);
    run_op(16, 3, 3, "R11", 0, 0);

    // R5 full scans with mixed signed weights, edge targets
    wmode = 1; active = NODES;
    for (int k = 0; k < 4; k++) begin
      wseed = k * 13 + 5;
      fill_codes(2, k * 3);
      run_op((k == 0) ? 16 : (k == 1) ? 5 : (k == 2) ? 11 : 2, (k == 3) ? 255 : k * 60, k, "R5", 0, 0);
    end
    run_op(16, 0, 3, "R5", 0, 0);
    run_op(7, 255, 1, "R5", 0, 0);

    // R6 saturation
    wmode = 0; wconst = 127; active = NODES;
    fill_codes(0, 1); set_code(10, 0);
    run_op(16, 10, 0, "R6 high", 0, 0);
    fill_codes(0, 0); set_code(10, 0);
    run_op(16, 10, 0, "R6 low", 0, 0);
    wconst = -100; fill_codes(0, 0); set_code(10, 0);
    run_op(16, 10, 0, "R6 neg weights", 0, 0);
    active = 2; wconst = 127; fill_codes(0, 5); set_code(0, 4); set_code(1, 5);
    run_op(16, 0, 0, "R6 exact high", 0, 0);
    wconst = -128;
    run_op(16, 0, 0, "R6 exact low", 0, 0);

    // R9 back-pressure, R7 request during busy
    wmode = 1; active = NODES; wseed = 77; fill_codes(1, 0);
    run_op(16, 100, 1, "R9", 6, 0);
    run_op(9, 17, 2, "R7", 3, 1);
    run_op(12, 200, 0, "R9", 1, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule